// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This block assembles one 128-bit result from two 128-bit operands. The two operands are joined into a pool of 32 bytes, and a 128-bit control word holds one selector byte for each of the 16 result bytes. Each result byte can therefore be any byte of either operand. Any pattern works: reordered bytes, the same byte used several times, or some bytes left out.

An operation is offered with `in_valid`. It is taken on any rising clock edge where both `in_valid` and `in_ready` are high. The result appears in an output register one clock later, flagged by `out_valid`. The unit never stalls, so a fresh operation can enter on every cycle.

A two-state controller tracks whether the output register holds a fresh result:

- `S_EMPTY` goes to `S_FULL` on the accept transition, when an operation is taken.
- `S_FULL` stays in `S_FULL` on the accept transition.
- `S_FULL` goes to `S_EMPTY` on the idle transition, when no operation is offered.
- `S_EMPTY` stays in `S_EMPTY` on the idle transition.

Top module: `byte_permute_unit`

## Requirements
- R1: An operation taken on a rising edge raises `out_valid` after that same edge and shows its result on `out_data` for the following cycle.
- R2: Result byte i is taken from the joined pool at pool index s, where s is the low 5 bits of control byte i. Values 0 to 15 address bytes 0 to 15 of `in_a`, and values 16 to 31 address bytes 0 to 15 of `in_b`.
- R3: The top 3 bits of every control byte have no effect on the result.
- R4: Several result bytes may name the same source byte, and a control word that sets every selector to one value s repeats that source byte 16 times.
- R5: Whenever reset is released, `in_ready` is high, and operations presented on consecutive cycles each produce a correct result on consecutive cycles.
- R6: After an edge with `in_valid` low, `out_valid` is low and `out_data` keeps its previous value, even if the other inputs change.
- R7: While `rst_n` is low, `in_ready` is low, `out_valid` is low and `out_data` is all zeros.
- R8: Byte 0 is the most significant byte (bits 127:120) of `in_a`, `in_b`, `in_ctrl` and `out_data`; control bytes 0 to 15 in order pass `in_a` through unchanged, and control bytes 16 to 31 in order pass `in_b` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation |
| in_a | input | 128 | First source operand, pool bytes 0 to 15 |
| in_b | input | 128 | Second source operand, pool bytes 16 to 31 |
| in_ctrl | input | 128 | One selector byte for each result byte |
| out_valid | output | 1 | `out_data` holds a fresh result |
| out_data | output | 128 | Registered permuted result |

## Verification
Four relations are checked on every clock edge:

- the latency from accept to `out_valid`;
- the drop of `out_valid` after an idle edge;
- the hold of `out_data` across idle edges;
- the correctness of result byte 0 against the selector and operands of the previous edge.

The other fifteen byte lanes, whether the top selector bits are ignored, the byte numbering, and repeated-byte patterns can only be shown by the bench's scenarios:

- sweeps that set every selector value in all lanes;
- selectors with the top bits varied;
- pass-through patterns;
- long back-to-back streams compared against an arithmetic model.

// File: rtl/permute_pkg.sv
package permute_pkg;

    localparam int unsigned DEF_LANES  = 16;
    localparam int unsigned DEF_BYTE_W = 8;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } perm_state_t;

endpackage

// File: rtl/perm_lane_mux.sv
module perm_lane_mux #(
    parameter int unsigned LANES  = 16,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned POOL_N = 2 * LANES,
    localparam int unsigned SEL_W  = $clog2(POOL_N)
) (
    input  logic [POOL_N*BYTE_W-1:0] pool,
    input  logic [SEL_W-1:0]         sel,
    output logic [BYTE_W-1:0]        lane_out
);

    // Pool index 0 is the most significant byte of the pool.
    always_comb begin
        lane_out = '0;
        for (int unsigned k = 0; k < POOL_N; k++) begin
            if (sel == SEL_W'(k)) begin
                lane_out = pool[(POOL_N-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
    import permute_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load_en,
    output logic out_valid
);

    perm_state_t state_q;
    perm_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: accept versus idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: state_d = (in_valid && rst_n) ? S_FULL : S_EMPTY;
            S_FULL:  state_d = (in_valid && rst_n) ? S_FULL : S_EMPTY;
            default: state_d = S_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready  = rst_n;
        load_en   = in_valid && rst_n;
        out_valid = (state_q == S_FULL);
    end

    a_r1_valid_after_accept: assert property (
        @(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid
    );

    a_r6_valid_drops: assert property (
        @(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid
    );

endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import permute_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned VEC_W  = LANES * BYTE_W,
    localparam int unsigned POOL_N = 2 * LANES,
    localparam int unsigned SEL_W  = $clog2(POOL_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [VEC_W-1:0] in_ctrl,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);

    logic [2*VEC_W-1:0]      src_pool;
    logic [VEC_W-1:0]        perm_w;
    logic                    load_en;
    logic [LANES-1:0]        unused_ctl_hi;

    assign src_pool = {in_a, in_b};

    perm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    // One selector lane per result byte; lane 0 is the top byte.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned HI = VEC_W - 1 - i * BYTE_W;
        perm_lane_mux #(
            .LANES  (LANES),
            .BYTE_W (BYTE_W)
        ) u_mux (
            .pool     (src_pool),
            .sel      (in_ctrl[HI-BYTE_W+1 +: SEL_W]),
            .lane_out (perm_w[HI -: BYTE_W])
        );
        assign unused_ctl_hi[i] = ^in_ctrl[HI -: (BYTE_W - SEL_W)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (load_en) begin
            out_data <= perm_w;
        end
    end

    a_r6_data_holds: assert property (
        @(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)
    );

    a_r2_top_byte: assert property (
        @(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
            out_data[VEC_W-1 -: BYTE_W] ==
            $past(src_pool[(POOL_N - 1 - int'(in_ctrl[VEC_W-BYTE_W +: SEL_W])) * BYTE_W +: BYTE_W])
    );

endmodule

// File: tb/byte_permute_unit_test.sv
module byte_permute_unit_test;

    localparam int NB = 16;
    localparam int VW = 128;
    localparam int MAXS = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic [VW-1:0] in_ctrl = '0;
    logic          in_ready;
    logic          out_valid;
    logic [VW-1:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [VW-1:0] sa [MAXS];
    logic [VW-1:0] sb [MAXS];
    logic [VW-1:0] sc [MAXS];

    always #4 clk = ~clk;

    byte_permute_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_ctrl(in_ctrl),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] byte_at(logic [VW-1:0] v, int k);
        return 8'(v >> (8 * (NB - 1 - k)));
    endfunction

    function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                            logic [VW-1:0] c);
        logic [VW-1:0] r;
        int s;
        logic [7:0] x;
        r = '0;
        for (int i = 0; i < NB; i++) begin
            s = int'(byte_at(c, i)) % 32;
            x = (s < NB) ? byte_at(a, s) : byte_at(b, s - NB);
            r = {r[VW-9:0], x};
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] mix(int seed);
        logic [VW-1:0] r;
        r = '0;
        for (int i = 0; i < NB; i++) r = {r[VW-9:0], 8'(seed * 37 + i * 91 + (seed >> 2) + i * i)};
        return r;
    endfunction

    task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_stream(int n, string req);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk({req, " valid"}, VW'(out_valid), VW'(1));
                chk({req, " data"}, out_data, model(sa[k-1], sb[k-1], sc[k-1]));
            end
            chk("R5 ready", VW'(in_ready), VW'(1));
            if (k < n) begin
                in_valid = 1'b1; in_a = sa[k]; in_b = sb[k]; in_ctrl = sc[k];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] c;
        logic [VW-1:0] last;
        // R7 reset state
        repeat (3) @(negedge clk);
        in_valid = 1'b1; in_a = mix(1); in_ctrl = mix(2);
        @(negedge clk);
        chk("R7 ready in reset", VW'(in_ready), VW'(0));
        chk("R7 valid in reset", VW'(out_valid), VW'(0));
        chk("R7 data in reset", out_data, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 ready after reset", VW'(in_ready), VW'(1));
        chk("R6 idle valid", VW'(out_valid), VW'(0));

        // R4: every selector value repeated in all lanes
        for (int s = 0; s < 32; s++) begin
            c = '0;
            for (int i = 0; i < NB; i++) c = {c[VW-9:0], 8'(s)};
            sa[s] = mix(s + 3); sb[s] = mix(s + 101); sc[s] = c;
        end
        run_stream(32, "R4 repeated byte");

        // R3: top selector bits varied, results must match the masked model
        for (int s = 0; s < 32; s++) begin
            c = '0;
            for (int i = 0; i < NB; i++) c = {c[VW-9:0], 8'(((i * 7 + s) % 32) | (((s + i) % 8) << 5))};
            sa[s] = mix(s + 200); sb[s] = mix(s + 300); sc[s] = c;
        end
        run_stream(32, "R3 top bits ignored");

        // R8: pass-through orderings
        c = '0;
        for (int i = 0; i < NB; i++) c = {c[VW-9:0], 8'(i)};
        sa[0] = mix(7); sb[0] = mix(8); sc[0] = c;
        c = '0;
        for (int i = 0; i < NB; i++) c = {c[VW-9:0], 8'(NB + i)};
        sa[1] = mix(9); sb[1] = mix(10); sc[1] = c;
        for (int k = 0; k <= 2; k++) begin
            @(negedge clk);
            if (k == 1) chk("R8 pass A", out_data, sa[0]);
            if (k == 2) chk("R8 pass B", out_data, sb[1]);
            if (k < 2) begin
                in_valid = 1'b1; in_a = sa[k]; in_b = sb[k]; in_ctrl = sc[k];
            end else in_valid = 1'b0;
        end
        // R8/R2: reversed order of A, byte 0 must land in byte 15
        @(negedge clk);
        c = '0;
        for (int i = 0; i < NB; i++) c = {c[VW-9:0], 8'(NB - 1 - i)};
        in_valid = 1'b1; in_a = {8'hC3, {(VW-8){1'b0}}}; in_b = '1; in_ctrl = c;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 reverse top byte", out_data, {{(VW-8){1'b0}}, 8'hC3});

        // R5/R2: long back-to-back mixed stream
        for (int s = 0; s < MAXS; s++) begin
            sa[s] = mix(s * 5 + 11); sb[s] = mix(s * 3 + 17); sc[s] = mix(s * 13 + 29);
        end
        run_stream(MAXS, "R2 mixed stream");

        // R6: idle with changing inputs holds data, drops valid
        last = model(sa[MAXS-1], sb[MAXS-1], sc[MAXS-1]);
        for (int k = 0; k < 4; k++) begin
            in_a = mix(k + 900); in_b = mix(k + 950); in_ctrl = mix(k + 990);
            @(negedge clk);
            chk("R6 valid low", VW'(out_valid), VW'(0));
            chk("R6 data held", out_data, last);
        end

        // R1: single operation after idle
        in_valid = 1'b1; in_a = mix(61); in_b = mix(62); in_ctrl = mix(63);
        chk("R1 valid before edge", VW'(out_valid), VW'(0));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 valid after edge", VW'(out_valid), VW'(1));
        chk("R1 data after edge", out_data, model(mix(61), mix(62), mix(63)));
        @(negedge clk);
        chk("R1 single cycle valid", VW'(out_valid), VW'(0));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule